// File: doc/BRIEF.md
# Multi-lane 8b/10b symbol decoder

The block turns symbol-aligned 10-bit line codes into bytes, handling one, two or four symbols in every clock. Each output byte comes with four flags: a control-character marker, a comma marker, a disparity-error marker and an invalid-code marker. One running disparity is carried from the lowest lane up through the higher lanes, and from one clock to the next.

A run-time enable picks between full decoding and a raw mode. In raw mode the undecoded symbols are forwarded unchanged and all flags stay low. Three build-time parameters set which commas raise the comma flag. One admits commas that open with the plus pattern, one admits commas that open with the minus pattern, and one limits the flag to the three standard comma characters. The result appears one clock after the symbols are presented.

Top module: `sym10_rx_decoder`

## Requirements
- R1: Every output is registered and reflects the input presented one clock earlier. While `rst_n` is low, every output is zero and the running disparity is set to negative.
- R2: Symbol bit 0 is line bit a, and bits 1..9 are b, c, d, e, i, f, g, h, j. A valid data character decodes to its byte, with byte bit 0 = A and byte bit 7 = H, and `k_o` low.
- R3: The control characters are K28.0 to K28.7 (bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC) and K23.7, K27.7, K29.7, K30.7 (0xF7, 0xFB, 0xFD, 0xFE). Each decodes to its byte with `k_o` high for that lane.
- R4: Running disparity runs from lane 0 upward and on into the next word. Each sub-block (abcdei, then fghj) with more ones than zeros sets it positive, fewer sets it negative, and a balanced one leaves it unchanged.
- R5: A symbol that is valid only in the column opposite to the current running disparity raises `disp_err_o` for its lane. Its byte and K flag are still decoded.
- R6: A symbol valid in neither column raises `code_err_o` and gives byte 0x00 with `k_o` and `disp_err_o` low.
- R7: Without the standard-only restriction, the comma flag is raised when line bits a..f equal 0011111 (plus pattern) and `POS_COMMA_EN` is set, or equal 1100000 (minus pattern) and `NEG_COMMA_EN` is set. This applies even on an invalid symbol.
- R8: With `STD_COMMA_ONLY` set, the comma flag additionally needs a valid K28.1, K28.5 or K28.7, with no code error, in an enabled polarity.
- R9: With `dec_en` low, `data_o` equals the raw input symbols and every flag is low.
- R10: With `dec_en` low, the running disparity is held unchanged.
- R11: While decoding, lane n's byte sits in `data_o[8n+7:8n]` and bits `LANES*8` and above are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_en | input | 1 | 1 = decode, 0 = raw pass-through |
| sym_i | input | LANES*10 | Symbols, lane n in bits 10n+9:10n |
| data_o | output | LANES*10 | Decoded bytes or raw symbols |
| k_o | output | LANES | Control-character flag per lane |
| comma_o | output | LANES | Comma flag per lane |
| disp_err_o | output | LANES | Disparity-error flag per lane |
| code_err_o | output | LANES | Invalid-code flag per lane |

## Verification
The hardest situations to reach are a disparity error and the disparity being held through raw mode. A correct encoder stream never produces a wrong-column symbol, and raw mode shows nothing of the disparity register at the ports. For the first, the stimulus encodes K28.5 in the column opposite to the tracked disparity and injects it mid-stream. For the second, it first forwards raw symbols that would flip the disparity if they were decoded. It then resumes with characters whose first sub-block is unbalanced, so any drift of the held disparity shows up as a spurious disparity error. A second instance built with standard-only, plus-polarity commas receives the same stream, which separates the comma policies on an invalid symbol that still carries the plus pattern.

// File: rtl/sym10_pkg.sv
package sym10_pkg;

    typedef enum logic {RD_NEG = 1'b0, RD_POS = 1'b1} rd_e;

    // 5b -> abcdei for the negative column, MSB = a
    function automatic logic [5:0] six_neg(input logic [4:0] x);
        logic [5:0] r;
        case (x)
            5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
            5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
            5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
            5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
            5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
            5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
            5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
            5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
            5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
            5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
            5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
            5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
            5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
            5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
            5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
            5'd30: r = 6'b011110;  default: r = 6'b101011;
        endcase
        return r;
    endfunction

    function automatic logic [5:0] six_code(input logic [4:0] x, input logic col_pos);
        logic [5:0] n;
        n = six_neg(x);
        if (!col_pos)                 return n;
        else if ($countones(n) != 3)  return ~n;
        else if (x == 5'd7)           return 6'b000111;
        else                          return n;
    endfunction

    // fghj for a data character, MSB = f
    function automatic logic [3:0] four_code(input logic [2:0] y, input logic mid_pos,
                                             input logic alt);
        logic [3:0] n;
        case (y)
            3'd0: n = 4'b1011;  3'd1: n = 4'b1001;
            3'd2: n = 4'b0101;  3'd3: n = 4'b1100;
            3'd4: n = 4'b1101;  3'd5: n = 4'b1010;
            3'd6: n = 4'b0110;  default: n = alt ? 4'b0111 : 4'b1110;
        endcase
        if (!mid_pos)                 return n;
        else if ($countones(n) != 2)  return ~n;
        else if (y == 3'd3)           return 4'b0011;
        else                          return n;
    endfunction

    function automatic logic alt_rule(input logic [4:0] x, input logic mid_pos, input logic [2:0] y);
        if (y != 3'd7) return 1'b0;
        if (mid_pos)   return (x == 5'd11) || (x == 5'd13) || (x == 5'd14);
        return (x == 5'd17) || (x == 5'd18) || (x == 5'd20);
    endfunction

    function automatic logic ctrl_x7(input logic [4:0] x);
        return (x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30);
    endfunction

    function automatic logic [5:0] k28_six(input logic col_pos);
        return col_pos ? 6'b110000 : 6'b001111;
    endfunction

    function automatic logic [3:0] k28_four(input logic [2:0] y, input logic col_pos);
        logic [3:0] n;
        n = four_code(y, 1'b1, y == 3'd7);
        return col_pos ? ~n : n;
    endfunction

    // sub-block disparity rule
    function automatic logic rd_step(input logic rd, input int ones, input int half);
        if (ones > half)      return 1'b1;
        else if (ones < half) return 1'b0;
        else                  return rd;
    endfunction

endpackage

// File: rtl/sym10_lane_dec.sv
module sym10_lane_dec
    import sym10_pkg::*;
(
    input  logic [9:0] sym_i,
    input  logic       rd_i,
    output logic [7:0] byte_o,
    output logic       k_o,
    output logic       derr_o,
    output logic       cerr_o,
    output logic       plus_o,
    output logic       minus_o,
    output logic       std_o,
    output logic       rd_o
);
    logic [5:0] s6;
    logic [3:0] s4;
    logic [1:0] hit;
    logic [7:0] byt [2];
    logic [1:0] kk;
    logic       hit6;
    logic [4:0] xv;
    logic       mid;
    logic       col_pos;
    logic       use_pos;

    always_comb begin
        s6 = {sym_i[0], sym_i[1], sym_i[2], sym_i[3], sym_i[4], sym_i[5]};
        s4 = {sym_i[6], sym_i[7], sym_i[8], sym_i[9]};
        hit6 = 1'b0;
        xv = '0;
        mid = 1'b0;
        col_pos = 1'b0;
        for (int c = 0; c < 2; c++) begin
            col_pos = (c == 1);
            mid = rd_step(col_pos, $countones(s6), 3);
            hit[c] = 1'b0;
            byt[c] = '0;
            kk[c] = 1'b0;
            hit6 = 1'b0;
            xv = '0;
            if (s6 == k28_six(col_pos)) begin
                for (int y = 0; y < 8; y++) begin
                    if (s4 == k28_four(y[2:0], col_pos)) begin
                        hit[c] = 1'b1;
                        byt[c] = {y[2:0], 5'd28};
                        kk[c]  = 1'b1;
                    end
                end
            end else begin
                for (int x = 0; x < 32; x++) begin
                    if (s6 == six_code(x[4:0], col_pos)) begin
                        hit6 = 1'b1;
                        xv   = x[4:0];
                    end
                end
                if (hit6) begin
                    for (int y = 0; y < 8; y++) begin
                        if (s4 == four_code(y[2:0], mid, alt_rule(xv, mid, y[2:0]))) begin
                            hit[c] = 1'b1;
                            byt[c] = {y[2:0], xv};
                        end
                    end
                    if (ctrl_x7(xv) && s4 == four_code(3'd7, mid, 1'b1)) begin
                        hit[c] = 1'b1;
                        byt[c] = {3'd7, xv};
                        kk[c]  = 1'b1;
                    end
                end
            end
        end

        use_pos = rd_i;
        derr_o  = 1'b0;
        cerr_o  = 1'b0;
        if (hit[rd_i]) begin
            use_pos = rd_i;
        end else if (hit[!rd_i]) begin
            use_pos = !rd_i;
            derr_o  = 1'b1;
        end else begin
            cerr_o  = 1'b1;
        end
        byte_o = cerr_o ? 8'h00 : byt[use_pos];
        k_o    = cerr_o ? 1'b0  : kk[use_pos];

        plus_o  = ({s6, s4[3]} == 7'b0011111);
        minus_o = ({s6, s4[3]} == 7'b1100000);
        std_o   = k_o && (byte_o == 8'h3C || byte_o == 8'hBC || byte_o == 8'hFC);
        rd_o    = rd_step(rd_step(rd_i, $countones(s6), 3), $countones(s4), 2);
    end

endmodule

// File: rtl/sym10_comma_chk.sv
module sym10_comma_chk #(
    parameter bit POS_EN   = 1'b1,
    parameter bit NEG_EN   = 1'b1,
    parameter bit STD_ONLY = 1'b0
) (
    input  logic plus_i,
    input  logic minus_i,
    input  logic std_i,
    output logic flag_o
);
    logic pol_ok;
    assign pol_ok = (plus_i & POS_EN) | (minus_i & NEG_EN);

    generate
        if (STD_ONLY) begin : g_std
            assign flag_o = pol_ok & std_i;
        end else begin : g_any
            logic unused_std;
            assign unused_std = std_i;
            assign flag_o = pol_ok;
        end
    endgenerate
endmodule

// File: rtl/sym10_rx_decoder.sv
module sym10_rx_decoder
    import sym10_pkg::*;
#(
    parameter int LANES          = 4,
    parameter bit POS_COMMA_EN   = 1'b1,
    parameter bit NEG_COMMA_EN   = 1'b1,
    parameter bit STD_COMMA_ONLY = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dec_en,
    input  logic [LANES*10-1:0]   sym_i,
    output logic [LANES*10-1:0]   data_o,
    output logic [LANES-1:0]      k_o,
    output logic [LANES-1:0]      comma_o,
    output logic [LANES-1:0]      disp_err_o,
    output logic [LANES-1:0]      code_err_o
);
    localparam int W10 = LANES * 10;
    localparam int W8  = LANES * 8;

    typedef struct packed {
        logic [W10-1:0]   data;
        logic [LANES-1:0] k;
        logic [LANES-1:0] comma;
        logic [LANES-1:0] derr;
        logic [LANES-1:0] cerr;
        rd_e              rd;
    } state_t;

    state_t st_d, st_q;

    logic [LANES:0]   rd_chain;
    logic [7:0]       ln_byte [LANES];
    logic [LANES-1:0] ln_k, ln_derr, ln_cerr, ln_comma;

    assign rd_chain[0] = st_q.rd;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic plus_w, minus_w, std_w;
            sym10_lane_dec u_dec (
                .sym_i   (sym_i[i*10 +: 10]),
                .rd_i    (rd_chain[i]),
                .byte_o  (ln_byte[i]),
                .k_o     (ln_k[i]),
                .derr_o  (ln_derr[i]),
                .cerr_o  (ln_cerr[i]),
                .plus_o  (plus_w),
                .minus_o (minus_w),
                .std_o   (std_w),
                .rd_o    (rd_chain[i+1])
            );
            sym10_comma_chk #(
                .POS_EN   (POS_COMMA_EN),
                .NEG_EN   (NEG_COMMA_EN),
                .STD_ONLY (STD_COMMA_ONLY)
            ) u_comma (
                .plus_i  (plus_w),
                .minus_i (minus_w),
                .std_i   (std_w),
                .flag_o  (ln_comma[i])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (dec_en) begin
            st_d.data = '0;
            for (int i = 0; i < LANES; i++) begin
                st_d.data[i*8 +: 8] = ln_byte[i];
            end
            st_d.k     = ln_k;
            st_d.comma = ln_comma;
            st_d.derr  = ln_derr;
            st_d.cerr  = ln_cerr;
            st_d.rd    = rd_e'(rd_chain[LANES]);
        end else begin
            st_d.data  = sym_i;
            st_d.k     = '0;
            st_d.comma = '0;
            st_d.derr  = '0;
            st_d.cerr  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '0, k: '0, comma: '0, derr: '0, cerr: '0, rd: RD_NEG};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o     = st_q.data;
    assign k_o        = st_q.k;
    assign comma_o    = st_q.comma;
    assign disp_err_o = st_q.derr;
    assign code_err_o = st_q.cerr;

    // R9: raw symbols forwarded unchanged
    p_pass_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> data_o == $past(sym_i));

    // R9: all flags quiet in raw mode
    p_pass_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> (k_o | comma_o | disp_err_o | code_err_o) == '0);

    // R10: disparity frozen while not decoding
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> st_q.rd == $past(st_q.rd));

    // R11: upper bits cleared while decoding
    p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |=> data_o[W10-1:W8] == '0);

    // R6: an invalid code is neither a disparity error nor a control char
    p_code_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_err_o & disp_err_o) | (code_err_o & k_o)) == '0);

    generate
        if (STD_COMMA_ONLY) begin : g_std_chk
            // R8: restricted comma never accompanies an invalid code
            p_std_comma_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (comma_o & code_err_o) == '0);
        end
    endgenerate

endmodule

// File: tb/sym10_rx_decoder_tb.sv
module sym10_rx_decoder_tb;
    localparam int LANES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_en = 1'b0;
    logic [39:0] sym_i = '0;
    logic [39:0] data_a, data_b;
    logic [3:0]  k_a, cm_a, de_a, ce_a;
    logic [3:0]  k_b, cm_b, de_b, ce_b;

    always #10 clk = ~clk;

    sym10_rx_decoder #(.LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .sym_i(sym_i),
        .data_o(data_a), .k_o(k_a), .comma_o(cm_a), .disp_err_o(de_a), .code_err_o(ce_a));

    sym10_rx_decoder #(.LANES(LANES), .POS_COMMA_EN(1'b1), .NEG_COMMA_EN(1'b0),
                       .STD_COMMA_ONLY(1'b1)) u_dut_std (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .sym_i(sym_i),
        .data_o(data_b), .k_o(k_b), .comma_o(cm_b), .disp_err_o(de_b), .code_err_o(ce_b));

    typedef struct packed {
        logic [39:0] data;
        logic [3:0]  k, ca, cb, de, ce;
    } exp_t;

    exp_t  q_exp [$];
    string q_tag [$];
    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    bit    mdl_rd = 1'b0;

    task automatic chk(input string tag, input string what, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- bench encoder model ----------------
    function automatic logic [5:0] m6(input logic [4:0] x);
        logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
                               6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
                               6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
                               6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
                               6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
                               6'b011110, 6'b101011};
        return t[x];
    endfunction

    function automatic logic [3:0] m4(input logic [2:0] y, input bit alt);
        logic [3:0] t [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
        return (y == 3'd7 && alt) ? 4'b0111 : t[y];
    endfunction

    function automatic logic [3:0] mk28(input logic [2:0] y);
        logic [3:0] t [8] = '{4'b0100, 4'b1001, 4'b0101, 4'b0011, 4'b0010, 4'b1010, 4'b0110, 4'b1000};
        return t[y];
    endfunction

    function automatic bit rd_after(input bit rd, input logic [9:0] lit);
        bit r = rd;
        int o6 = $countones(lit[9:4]);
        int o4 = $countones(lit[3:0]);
        if (o6 > 3) r = 1; else if (o6 < 3) r = 0;
        if (o4 > 2) r = 1; else if (o4 < 2) r = 0;
        return r;
    endfunction

    function automatic logic [9:0] rev10(input logic [9:0] v);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = v[9-i];
        return r;
    endfunction

    // returns literal {abcdei,fghj}, MSB = a
    function automatic logic [9:0] enc_lit(input logic [7:0] b, input bit k, input bit rd);
        logic [4:0] x = b[4:0];
        logic [2:0] y = b[7:5];
        logic [5:0] s;
        logic [3:0] f;
        bit mid, alt;
        if (k && x == 5'd28) begin
            s = 6'b001111;
            f = mk28(y);
            return rd ? ~{s, f} : {s, f};
        end
        s = m6(x);
        if (rd) begin
            if ($countones(s) != 3) s = ~s;
            else if (x == 5'd7) s = 6'b000111;
        end
        mid = rd;
        if ($countones(s) > 3) mid = 1; else if ($countones(s) < 3) mid = 0;
        alt = k || (!mid && (x == 17 || x == 18 || x == 20)) || (mid && (x == 11 || x == 13 || x == 14));
        f = m4(y, alt);
        if (mid) begin
            if ($countones(f) != 2) f = ~f;
            else if (y == 3'd3) f = 4'b0011;
        end
        return {s, f};
    endfunction

    function automatic bit is_std_comma(input logic [7:0] b, input bit k);
        return k && (b == 8'h3C || b == 8'hBC || b == 8'hFC);
    endfunction

    // ---------------- driver ----------------
    task automatic drive(input bit en, input logic [39:0] s, input exp_t e, input string tag);
        @(negedge clk);
        dec_en = en;
        sym_i  = s;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // valid characters, encoded from the tracked disparity
    task automatic send_enc(input logic [31:0] bytes, input logic [3:0] ks, input string tag);
        logic [39:0] s;
        exp_t e;
        e = '0;
        for (int l = 0; l < 4; l++) begin
            logic [9:0] lit;
            lit = enc_lit(bytes[l*8 +: 8], ks[l], mdl_rd);
            s[l*10 +: 10] = rev10(lit);
            e.data[l*8 +: 8] = bytes[l*8 +: 8];
            e.k[l]  = ks[l];
            e.ca[l] = is_std_comma(bytes[l*8 +: 8], ks[l]);
            e.cb[l] = is_std_comma(bytes[l*8 +: 8], ks[l]) && !mdl_rd;
            mdl_rd  = rd_after(mdl_rd, lit);
        end
        drive(1'b1, s, e, tag);
    endtask

    // ---------------- monitor ----------------
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                exp_t  e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                chk(t, "data",     data_a,       e.data);
                chk(t, "k",        {36'b0, k_a}, {36'b0, e.k});
                chk(t, "comma",    {36'b0, cm_a}, {36'b0, e.ca});
                chk(t, "disp_err", {36'b0, de_a}, {36'b0, e.de});
                chk(t, "code_err", {36'b0, ce_a}, {36'b0, e.ce});
                chk(t, "std data", data_b,       e.data);
                chk(t, "std comma", {36'b0, cm_b}, {36'b0, e.cb});
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        #(20 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        exp_t e;
        logic [39:0] s;
        logic [9:0]  lit;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset data", data_a, '0);
        chk("R1", "reset flags", {24'b0, k_a, cm_a, de_a, ce_a}, '0);
        rst_n = 1'b1;

        // R2 R4 R11: every byte value across lanes, disparity carried along
        for (int i = 0; i < 64; i++) begin
            logic [31:0] b;
            for (int l = 0; l < 4; l++) b[l*8 +: 8] = 8'((i * 4 + l) * 7 + 3);
            send_enc(b, 4'b0000, "R2/R4/R11 data");
        end
        // R2: alternate .7 forms and D.7 in both columns
        send_enc(32'hF1F2F4EB, 4'b0000, "R2 alt7");
        send_enc(32'hEDEE0707, 4'b0000, "R2 alt7");
        send_enc(32'h00000000, 4'b0000, "R4 D0.0 chain");
        send_enc(32'h07070707, 4'b0000, "R4 D7.0 chain");

        // R3 R7: all control characters, both columns
        for (int rep = 0; rep < 2; rep++) begin
            send_enc(32'h7C5C3C1C, 4'b1111, "R3 K28 low");
            send_enc(32'hFCDCBC9C, 4'b1111, "R3/R7 K28 high");
            send_enc(32'hFEFDFBF7, 4'b1111, "R3 Kx.7");
            send_enc(32'h00BC00BC, 4'b0101, "R7/R8 comma mix");
        end

        // R5: K28.5 in the wrong column on lane 0, twice
        for (int rep = 0; rep < 2; rep++) begin
            bit r0;
            r0  = mdl_rd;
            lit = enc_lit(8'hBC, 1'b1, !r0);
            s = '0;
            e = '0;
            s[9:0] = rev10(lit);
            e.data[7:0] = 8'hBC; e.k[0] = 1; e.de[0] = 1; e.ca[0] = 1; e.cb[0] = r0;
            mdl_rd = rd_after(mdl_rd, lit);
            for (int l = 1; l < 4; l++) begin
                logic [9:0] lt;
                lt = enc_lit(8'h4A, 1'b0, mdl_rd);
                s[l*10 +: 10] = rev10(lt);
                e.data[l*8 +: 8] = 8'h4A;
                mdl_rd = rd_after(mdl_rd, lt);
            end
            drive(1'b1, s, e, "R5 disparity error");
            send_enc(32'h00000000, 4'b0000, "R5 recovery");
        end

        // R6 R7 R8: invalid all-zero, invalid with plus pattern
        s = '0;
        e = '0;
        lit = 10'b0000000000;
        s[9:0] = rev10(lit);
        e.ce[0] = 1;
        mdl_rd = rd_after(mdl_rd, lit);
        lit = 10'b0011111111;
        s[19:10] = rev10(lit);
        e.ce[1] = 1; e.ca[1] = 1; e.cb[1] = 0;
        mdl_rd = rd_after(mdl_rd, lit);
        for (int l = 2; l < 4; l++) begin
            logic [9:0] lt;
            lt = enc_lit(8'hBC, 1'b1, mdl_rd);
            s[l*10 +: 10] = rev10(lt);
            e.data[l*8 +: 8] = 8'hBC; e.k[l] = 1; e.ca[l] = 1; e.cb[l] = !mdl_rd;
            mdl_rd = rd_after(mdl_rd, lt);
        end
        drive(1'b1, s, e, "R6/R7/R8 invalid");
        send_enc(32'h12345678, 4'b0000, "R6 recovery");

        // R9 R10: raw mode with symbols that would flip disparity if decoded
        for (int rep = 0; rep < 3; rep++) begin
            s = mdl_rd ? 40'h0 : {4{10'h3FF}};
            if (rep == 1) s = 40'hA5_5A3C_C3F0 & (mdl_rd ? 40'h0 : {4{10'h3FF}});
            e = '0;
            e.data = s;
            drive(1'b0, s, e, "R9 raw");
        end
        send_enc(32'h00000000, 4'b0000, "R10 held disparity");
        send_enc(32'h0F0F0F0F, 4'b0000, "R10 after");

        repeat (4) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule